// File: doc/BRIEF.md
# Configurable Parallel Bus Master

This block runs single read or write cycles on an external 8-bit parallel peripheral, such as a display controller, a serial-less EEPROM or a small memory. Internal logic loads an address, sets a handful of configuration fields and pulses a start request. The engine then walks a fixed sequence of phases on the pins: optional address-latch phases, a setup phase, a strobe phase and a hold phase. Each of the last three lasts one cycle plus its programmed wait count. Read data is captured into a register, and the address can step up or down after every transfer.

Three address/data arrangements are supported. In demultiplexed mode every address bit has its own pin. In partially multiplexed mode the low address byte goes out on the data lines, marked by a low-byte latch strobe, and the upper bits stay on address pins. In fully multiplexed mode the low byte and then the high byte go out on the data lines, each with its own latch strobe. Strobes are either a separate read and write pair, or a read/not-write level plus an enable pulse. The chip select, the strobes and the latch signals each have their own active level. When the chip select is disabled, its pin carries the top address bit.

States: `PH_IDLE`, `PH_ALO` (low address byte latch), `PH_AHI` (high address byte latch), `PH_SETUP`, `PH_STRB`, `PH_HOLD`. Transitions:
- IDLE→ALO on start in the partial or full mode.
- IDLE→SETUP on start in demultiplexed mode.
- ALO→SETUP in partial mode, and ALO→AHI otherwise.
- AHI→SETUP.
- SETUP→STRB, STRB→HOLD and HOLD→IDLE, each when its wait counter reaches zero.

Top module: `par_bus_master`

## Requirements
- R1: After a start request, `busy` is high for exactly A+(S+1)+(T+1)+(H+1) cycles. A is 0, 1 or 2 for `cfg_mux` 0 (demultiplexed), 1 (partial) or 2 (full). S, T and H are the setup, strobe and hold wait counts.
- R2: While busy, `pin_addr` carries the effective address bits [10:0] in mode 0 and {bits [10:8], 8'h00} in mode 1, and is all zeros in mode 2.
- R3: In modes 1 and 2, the first busy cycle drives the low effective address byte on `pin_d_out` with `pin_d_oe` high and the low latch active. In mode 2 the next cycle drives effective bits [11:8], zero-extended, with the high latch active. No latch is active outside these cycles.
- R4: With `cfg_style`=0, the read strobe (`pin_rd_rnw`) is active only for reads and the write strobe (`pin_wr_en`) only for writes. It is active for exactly T+1 cycles, and the two strobes are never active together.
- R5: With `cfg_style`=1, `pin_rd_rnw` is 1 for a read and 0 for a write while busy and 1 when idle. `pin_wr_en` is active for exactly T+1 cycles.
- R6: Each of chip select, strobes and latches is active at the level given by its polarity bit (1 = active high) and sits at the opposite level when not active.
- R7: During a write, `pin_d_out` equals `wdata` with `pin_d_oe` high throughout the strobe phase. During the data phases of a read, and whenever idle, `pin_d_oe` is low.
- R8: A read captures `pin_d_in` on the clock edge that ends the strobe phase into `rdata`. A write leaves `rdata` unchanged.
- R9: At the end of each transfer, `cfg_step` 1 adds one to the address and 2 subtracts one, wrapping modulo the active width (11 bits with chip select, 12 without). `cfg_step` 0 leaves the address unchanged.
- R10: Start requests and `addr_load` arriving while busy are ignored, and `cur_addr` does not change during a transfer.
- R11: With `cfg_cs_en`=1, `pin_cs` is active exactly while busy. With `cfg_cs_en`=0, it carries address bit 11.
- R12: After reset, `busy`, `cur_addr`, `rdata` and `pin_d_oe` are zero and all control pins sit at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mux | input | 2 | 0 demultiplexed, 1 partial, 2 full multiplexing |
| cfg_style | input | 1 | 0 separate read/write strobes, 1 read/not-write plus enable |
| cfg_cs_en | input | 1 | 1 uses the chip select pin, 0 makes it address bit 11 |
| cfg_pol_cs | input | 1 | Active level of chip select |
| cfg_pol_strb | input | 1 | Active level of the strobes |
| cfg_pol_latch | input | 1 | Active level of the address latches |
| cfg_step | input | 2 | 0 hold, 1 increment, 2 decrement after each transfer |
| cfg_wait_setup | input | WAIT_W | Extra setup cycles |
| cfg_wait_strobe | input | WAIT_W | Extra strobe cycles |
| cfg_wait_hold | input | WAIT_W | Extra hold cycles |
| addr_in | input | ADDR_W | Address to load |
| addr_load | input | 1 | Loads `addr_in` when idle |
| wdata | input | DATA_W | Write data |
| start_rd | input | 1 | Starts a read (wins over a simultaneous write) |
| start_wr | input | 1 | Starts a write |
| busy | output | 1 | Transfer in progress |
| rdata | output | DATA_W | Last read byte |
| cur_addr | output | ADDR_W | Address register |
| pin_addr | output | ADDR_W-1 | Dedicated address pins |
| pin_cs | output | 1 | Chip select or address bit 11 |
| pin_ale_lo | output | 1 | Low address byte latch |
| pin_ale_hi | output | 1 | High address byte latch |
| pin_rd_rnw | output | 1 | Read strobe or read/not-write level |
| pin_wr_en | output | 1 | Write strobe or enable strobe |
| pin_d_out | output | DATA_W | Data lines, driven value |
| pin_d_oe | output | 1 | Data lines output enable |
| pin_d_in | input | DATA_W | Data lines, received value |

## Verification
A wrong phase or a wrong wait count shows at once as a busy window of the wrong length, or as a strobe or latch pulse count that is off by one. The bench counts these per transfer. A mis-stepped or overwritten address register shows up in `cur_addr` as soon as the transfer ends, and on the address pins and data lines during the next transfer. A capture taken on the wrong edge returns a byte the bench only presents outside the strobe phase, so it shows in `rdata` in the first idle cycle. Polarity and pin-mapping faults show on the pins in the very cycle in which the faulty phase runs.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALO,
        PH_AHI,
        PH_SETUP,
        PH_STRB,
        PH_HOLD
    } phase_t;

    localparam logic [1:0] MUX_DEMUX = 2'd0;
    localparam logic [1:0] MUX_PART  = 2'd1;

    localparam logic [1:0] STEP_INC  = 2'd1;
    localparam logic [1:0] STEP_DEC  = 2'd2;
endpackage

// File: rtl/pbm_seq.sv
module pbm_seq
    import pbm_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mux_mode,
    input  logic [WAIT_W-1:0] wait_setup,
    input  logic [WAIT_W-1:0] wait_strobe,
    input  logic [WAIT_W-1:0] wait_hold,
    input  logic              start_rd,
    input  logic              start_wr,
    output phase_t            phase,
    output logic              op_rd,
    output logic              capture,
    output logic              done
);
    phase_t            nxt;
    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W-1:0] cnt_init;

    // next-state decision
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:  if (start_rd || start_wr)
                          nxt = (mux_mode == MUX_DEMUX) ? PH_SETUP : PH_ALO;
            PH_ALO:   nxt = (mux_mode == MUX_PART) ? PH_SETUP : PH_AHI;
            PH_AHI:   nxt = PH_SETUP;
            PH_SETUP: if (cnt == '0) nxt = PH_STRB;
            PH_STRB:  if (cnt == '0) nxt = PH_HOLD;
            PH_HOLD:  if (cnt == '0) nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        unique case (nxt)
            PH_SETUP: cnt_init = wait_setup;
            PH_STRB:  cnt_init = wait_strobe;
            PH_HOLD:  cnt_init = wait_hold;
            default:  cnt_init = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            op_rd <= 1'b1;
        end else begin
            phase <= nxt;
            if (nxt != phase)
                cnt <= cnt_init;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
            if (phase == PH_IDLE && (start_rd || start_wr))
                op_rd <= start_rd;
        end
    end

    assign capture = (phase == PH_STRB) && (cnt == '0) && op_rd;
    assign done    = (phase == PH_HOLD) && (cnt == '0);
endmodule

// File: rtl/pbm_addr.sv
module pbm_addr
    import pbm_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mask,
    input  logic [1:0]        step_mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_load,
    input  logic              idle,
    input  logic              done,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (done) begin
            if (step_mode == STEP_INC)
                addr <= (addr + 1'b1) & mask;
            else if (step_mode == STEP_DEC)
                addr <= (addr - 1'b1) & mask;
        end else if (idle && addr_load) begin
            addr <= addr_in;
        end
    end
endmodule

// File: rtl/pbm_drive.sv
module pbm_drive
    import pbm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  phase_t            phase,
    input  logic              op_rd,
    input  logic [1:0]        mux_mode,
    input  logic              style,
    input  logic              cs_en,
    input  logic              pol_cs,
    input  logic              pol_strb,
    input  logic              pol_latch,
    input  logic [ADDR_W-1:0] ea,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-2:0] pin_addr,
    output logic              pin_cs,
    output logic              pin_ale_lo,
    output logic              pin_ale_hi,
    output logic              pin_rd_rnw,
    output logic              pin_wr_en,
    output logic [DATA_W-1:0] pin_d_out,
    output logic              pin_d_oe
);
    logic busy_i, strb_i, data_ph;

    // output decode from the registered phase
    always_comb begin
        busy_i  = (phase != PH_IDLE);
        strb_i  = (phase == PH_STRB);
        data_ph = (phase == PH_SETUP) || strb_i || (phase == PH_HOLD);

        if (mux_mode == MUX_DEMUX)
            pin_addr = ea[ADDR_W-2:0];
        else if (mux_mode == MUX_PART)
            pin_addr = {ea[ADDR_W-2:DATA_W], {DATA_W{1'b0}}};
        else
            pin_addr = '0;

        pin_cs     = cs_en ? ~(busy_i ^ pol_cs) : ea[ADDR_W-1];
        pin_ale_lo = ~((phase == PH_ALO) ^ pol_latch);
        pin_ale_hi = ~((phase == PH_AHI) ^ pol_latch);

        if (style) begin
            pin_rd_rnw = busy_i ? op_rd : 1'b1;
            pin_wr_en  = ~(strb_i ^ pol_strb);
        end else begin
            pin_rd_rnw = ~((strb_i && op_rd) ^ pol_strb);
            pin_wr_en  = ~((strb_i && !op_rd) ^ pol_strb);
        end

        unique case (phase)
            PH_ALO:  pin_d_out = ea[DATA_W-1:0];
            PH_AHI:  pin_d_out = DATA_W'(ea >> DATA_W);
            default: pin_d_out = wdata;
        endcase
        pin_d_oe = (phase == PH_ALO) || (phase == PH_AHI) || (data_ph && !op_rd);
    end
endmodule

// File: rtl/par_bus_master.sv
module par_bus_master
    import pbm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mux,
    input  logic              cfg_style,
    input  logic              cfg_cs_en,
    input  logic              cfg_pol_cs,
    input  logic              cfg_pol_strb,
    input  logic              cfg_pol_latch,
    input  logic [1:0]        cfg_step,
    input  logic [WAIT_W-1:0] cfg_wait_setup,
    input  logic [WAIT_W-1:0] cfg_wait_strobe,
    input  logic [WAIT_W-1:0] cfg_wait_hold,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start_rd,
    input  logic              start_wr,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-2:0] pin_addr,
    output logic              pin_cs,
    output logic              pin_ale_lo,
    output logic              pin_ale_hi,
    output logic              pin_rd_rnw,
    output logic              pin_wr_en,
    output logic [DATA_W-1:0] pin_d_out,
    output logic              pin_d_oe,
    input  logic [DATA_W-1:0] pin_d_in
);
    localparam logic [ADDR_W-1:0] MASK_CS  = {1'b0, {(ADDR_W-1){1'b1}}};
    localparam logic [ADDR_W-1:0] MASK_ALL = '1;

    phase_t            phase;
    logic              op_rd, capture, done;
    logic [ADDR_W-1:0] mask, ea;

    assign mask = cfg_cs_en ? MASK_CS : MASK_ALL;
    assign ea   = cur_addr & mask;
    assign busy = (phase != PH_IDLE);

    pbm_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .mux_mode(cfg_mux),
        .wait_setup(cfg_wait_setup), .wait_strobe(cfg_wait_strobe),
        .wait_hold(cfg_wait_hold), .start_rd(start_rd), .start_wr(start_wr),
        .phase(phase), .op_rd(op_rd), .capture(capture), .done(done)
    );

    pbm_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .mask(mask), .step_mode(cfg_step),
        .addr_in(addr_in), .addr_load(addr_load), .idle(!busy),
        .done(done), .addr(cur_addr)
    );

    pbm_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .phase(phase), .op_rd(op_rd), .mux_mode(cfg_mux), .style(cfg_style),
        .cs_en(cfg_cs_en), .pol_cs(cfg_pol_cs), .pol_strb(cfg_pol_strb),
        .pol_latch(cfg_pol_latch), .ea(ea), .wdata(wdata),
        .pin_addr(pin_addr), .pin_cs(pin_cs), .pin_ale_lo(pin_ale_lo),
        .pin_ale_hi(pin_ale_hi), .pin_rd_rnw(pin_rd_rnw), .pin_wr_en(pin_wr_en),
        .pin_d_out(pin_d_out), .pin_d_oe(pin_d_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (capture)
            rdata <= pin_d_in;
    end
endmodule

// File: rtl/pbm_chk.sv
module pbm_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              op_rd,
    input logic              style,
    input logic              cs_en,
    input logic              pol_cs,
    input logic              pol_strb,
    input logic              pol_latch,
    input logic              pin_cs,
    input logic              pin_ale_lo,
    input logic              pin_ale_hi,
    input logic              pin_rd_rnw,
    input logic              pin_wr_en,
    input logic              pin_d_oe,
    input logic [ADDR_W-1:0] cur_addr
);
    logic latch_on;
    assign latch_on = (pin_ale_lo == pol_latch) || (pin_ale_hi == pol_latch);

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !style |-> !((pin_rd_rnw == pol_strb) && (pin_wr_en == pol_strb)));

    assert_latch_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_on |-> busy);

    assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_rd && !latch_on) |-> !pin_d_oe);

    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pin_d_oe);

    assert_cs_tracks_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_en |-> ((pin_cs == pol_cs) == busy));

    assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_addr));
endmodule

bind par_bus_master pbm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_rd(op_rd), .style(cfg_style),
    .cs_en(cfg_cs_en), .pol_cs(cfg_pol_cs), .pol_strb(cfg_pol_strb),
    .pol_latch(cfg_pol_latch), .pin_cs(pin_cs), .pin_ale_lo(pin_ale_lo),
    .pin_ale_hi(pin_ale_hi), .pin_rd_rnw(pin_rd_rnw), .pin_wr_en(pin_wr_en),
    .pin_d_oe(pin_d_oe), .cur_addr(cur_addr)
);

// File: tb/par_bus_master_tb.sv
module par_bus_master_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mux;
    logic        cfg_style, cfg_cs_en, cfg_pol_cs, cfg_pol_strb, cfg_pol_latch;
    logic [1:0]  cfg_step;
    logic [3:0]  cfg_wait_setup, cfg_wait_strobe, cfg_wait_hold;
    logic [11:0] addr_in;
    logic        addr_load;
    logic [7:0]  wdata;
    logic        start_rd, start_wr;
    logic        busy;
    logic [7:0]  rdata;
    logic [11:0] cur_addr;
    logic [10:0] pin_addr;
    logic        pin_cs, pin_ale_lo, pin_ale_hi, pin_rd_rnw, pin_wr_en;
    logic [7:0]  pin_d_out;
    logic        pin_d_oe;
    logic [7:0]  pin_d_in;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] last_rd = 8'h00;

    always #10 clk = ~clk;

    par_bus_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_style(cfg_style),
        .cfg_cs_en(cfg_cs_en), .cfg_pol_cs(cfg_pol_cs), .cfg_pol_strb(cfg_pol_strb),
        .cfg_pol_latch(cfg_pol_latch), .cfg_step(cfg_step),
        .cfg_wait_setup(cfg_wait_setup), .cfg_wait_strobe(cfg_wait_strobe),
        .cfg_wait_hold(cfg_wait_hold), .addr_in(addr_in), .addr_load(addr_load),
        .wdata(wdata), .start_rd(start_rd), .start_wr(start_wr), .busy(busy),
        .rdata(rdata), .cur_addr(cur_addr), .pin_addr(pin_addr), .pin_cs(pin_cs),
        .pin_ale_lo(pin_ale_lo), .pin_ale_hi(pin_ale_hi), .pin_rd_rnw(pin_rd_rnw),
        .pin_wr_en(pin_wr_en), .pin_d_out(pin_d_out), .pin_d_oe(pin_d_oe),
        .pin_d_in(pin_d_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic xfer(input bit rd, input int idx);
        logic [11:0] a, msk, ea, exp_a, exp_pins;
        logic [7:0]  good, wd;
        logic        st_act, wrong, exp_cs;
        int nb = 0, nlo = 0, nhi = 0, nst = 0, nwrong = 0;
        int bad_adr = 0, bad_dat = 0, bad_pin = 0, bad_cs = 0;
        int n_adr, exp_busy;
        msk = cfg_cs_en ? 12'h7FF : 12'hFFF;
        case (idx % 4)
            0:       a = 12'h000;
            1:       a = 12'hFFF;
            2:       a = 12'h800;
            default: a = 12'(idx * 37);
        endcase
        ea = a & msk;
        cfg_step = 2'(idx % 3);
        addr_in = a; addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
        wd = 8'(idx * 7 + 1); good = 8'(idx * 13 + 5);
        wdata = wd; pin_d_in = ~good;
        if (rd) start_rd = 1'b1; else start_wr = 1'b1;
        @(negedge clk);
        start_rd = 1'b0; start_wr = 1'b0;
        case (cfg_mux)
            2'd0:    exp_pins = {1'b0, ea[10:0]};
            2'd1:    exp_pins = {1'b0, ea[10:8], 8'h00};
            default: exp_pins = 12'h000;
        endcase
        exp_cs = cfg_cs_en ? cfg_pol_cs : ea[11];
        while (busy && nb < 64) begin
            if (cfg_style == 1'b0) begin
                st_act = rd ? (pin_rd_rnw == cfg_pol_strb) : (pin_wr_en == cfg_pol_strb);
                wrong  = rd ? (pin_wr_en == cfg_pol_strb) : (pin_rd_rnw == cfg_pol_strb);
            end else begin
                st_act = (pin_wr_en == cfg_pol_strb);
                wrong  = (pin_rd_rnw != rd);
            end
            if (wrong) nwrong++;
            if (pin_ale_lo == cfg_pol_latch) begin
                nlo++;
                if (!pin_d_oe || pin_d_out != ea[7:0]) bad_adr++;
            end
            if (pin_ale_hi == cfg_pol_latch) begin
                nhi++;
                if (!pin_d_oe || pin_d_out != {4'h0, ea[11:8]}) bad_adr++;
            end
            if (st_act) begin
                nst++;
                if (!rd && (!pin_d_oe || pin_d_out != wd)) bad_dat++;
                if (rd && pin_d_oe) bad_dat++;
            end
            if ({1'b0, pin_addr} != exp_pins) bad_pin++;
            if (pin_cs != exp_cs) bad_cs++;
            pin_d_in = st_act ? good : ~good;
            if (nb == 1) begin
                start_rd = 1'b1; start_wr = 1'b1; addr_load = 1'b1; addr_in = ~a;
            end else begin
                start_rd = 1'b0; start_wr = 1'b0; addr_load = 1'b0;
            end
            nb++;
            @(negedge clk);
        end
        start_rd = 1'b0; start_wr = 1'b0; addr_load = 1'b0;
        n_adr = (cfg_mux == 2'd0) ? 0 : ((cfg_mux == 2'd1) ? 1 : 2);
        exp_busy = n_adr + int'(cfg_wait_setup) + int'(cfg_wait_strobe) + int'(cfg_wait_hold) + 3;
        check(nb == exp_busy, "R1 busy cycles", nb, exp_busy);
        check(nlo == (n_adr > 0 ? 1 : 0) && nhi == (n_adr > 1 ? 1 : 0) && bad_adr == 0,
              "R3 latch cycles/bytes", nlo * 100 + nhi * 10 + bad_adr, n_adr);
        check(bad_pin == 0, "R2 address pins", bad_pin, 0);
        check(nst == int'(cfg_wait_strobe) + 1,
              cfg_style ? "R5 enable strobe length" : "R4 strobe length",
              nst, int'(cfg_wait_strobe) + 1);
        check(nwrong == 0, cfg_style ? "R5 rnw level" : "R4 wrong strobe", nwrong, 0);
        check(bad_dat == 0, "R7 data drive", bad_dat, 0);
        check(bad_cs == 0, "R11 chip select pin", bad_cs, int'(exp_cs));
        if (rd) last_rd = good;
        check(rdata == last_rd, "R8 read capture", int'(rdata), int'(last_rd));
        case (idx % 3)
            1:       exp_a = (a + 12'd1) & msk;
            2:       exp_a = (a - 12'd1) & msk;
            default: exp_a = a;
        endcase
        check(cur_addr == exp_a, "R9 address step", int'(cur_addr), int'(exp_a));
        @(negedge clk);
        check(!busy, "R10 start while busy ignored", int'(busy), 0);
        check(pin_ale_lo != cfg_pol_latch && pin_ale_hi != cfg_pol_latch &&
              pin_wr_en != cfg_pol_strb && !pin_d_oe &&
              (cfg_style ? pin_rd_rnw == 1'b1 : pin_rd_rnw != cfg_pol_strb),
              "R6 idle levels", int'({pin_ale_lo, pin_ale_hi, pin_rd_rnw, pin_wr_en}), 0);
    endtask

    initial begin
        int idx = 0;
        rst_n = 1'b0;
        cfg_mux = 2'd0; cfg_style = 1'b0; cfg_cs_en = 1'b1;
        cfg_pol_cs = 1'b1; cfg_pol_strb = 1'b1; cfg_pol_latch = 1'b1;
        cfg_step = 2'd0; cfg_wait_setup = 4'd0; cfg_wait_strobe = 4'd0; cfg_wait_hold = 4'd0;
        addr_in = 12'h000; addr_load = 1'b0; wdata = 8'h00;
        start_rd = 1'b0; start_wr = 1'b0; pin_d_in = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && cur_addr == 12'h000 && rdata == 8'h00, "R12 reset registers",
              int'(cur_addr), 0);
        check(!pin_d_oe && !pin_cs && !pin_ale_lo && !pin_ale_hi && !pin_rd_rnw && !pin_wr_en,
              "R12 reset pins", int'({pin_cs, pin_ale_lo, pin_ale_hi, pin_rd_rnw, pin_wr_en}), 0);
        for (int m = 0; m < 3; m++)
        for (int st = 0; st < 2; st++)
        for (int ce = 0; ce < 2; ce++)
        for (int p = 0; p < 8; p++)
        for (int ws = 0; ws <= 2; ws += 2)
        for (int wt = 0; wt <= 3; wt += 3)
        for (int wh = 0; wh < 2; wh++)
        for (int rd = 0; rd < 2; rd++) begin
            cfg_mux = 2'(m); cfg_style = st[0]; cfg_cs_en = ce[0];
            cfg_pol_cs = p[0]; cfg_pol_strb = p[1]; cfg_pol_latch = p[2];
            cfg_wait_setup = 4'(ws); cfg_wait_strobe = 4'(wt); cfg_wait_hold = 4'(wh);
            @(negedge clk);
            xfer(rd[0], idx);
            idx++;
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule